// File: doc/BRIEF.md
# SPI Master Exchange Controller

This block is a register-programmed SPI master. Software fills a byte-wide transmit FIFO through a data port and loads a burst length. It then sets a start bit, and the exchange engine shifts that many bytes out on the serial data output while it collects the same number of bytes from the serial data input into a receive FIFO. Software waits until the receive occupancy reaches the burst length and then drains the receive port. Each burst should carry at most depth minus one bytes, so both FIFOs always have room.

The serial clock is not divided inside the block. A separate divider supplies a one-cycle strobe for every half period of the serial clock, and the engine moves the clock by one edge on each strobe. Clock polarity and phase can be set for any of the four usual SPI modes. Two select lines are provided. Each can be active-low or active-high, and the selected line can be driven by the engine for the length of a burst or set by software.

Top module: `spix_master`

## Requirements
- R1: After reset every register reads 0, the select lines are both 0 (the inactive level while active-low is off), and the serial clock and data outputs are 0.
- R2: Offsets 0x30 (burst length), 0x34 (transmit length) and 0x38 (burst control) store 24-bit values, and writing 0xFFFFFFFF reads back 0x00FFFFFF. The transfer control word at 0x08 reads back bits 0..2 and 4..7 as written, and bit 3 always reads 0.
- R3: A write to 0x200 pushes its low byte into the transmit FIFO, and a write to a full FIFO is dropped. FIFO status at 0x1C reports the receive count in [7:0] and the transmit count in [15:8]. A read of 0x300 returns the oldest receive byte and removes it.
- R4: Setting bit 31 of 0x08 exchanges exactly the burst length in bytes, and the bit clears itself when the last byte is done. While global control (0x04) bit 0 (enable) or bit 1 (master) is 0, the bit stays pending and no clock edge is produced.
- R5: Bytes go out most significant bit first. In mode 0 (0x08 bit 1 CPOL=0, bit 0 CPHA=0) the first bit is on the data output before the first clock edge and is sampled on the leading edge.
- R6: In modes 1 to 3 the clock rests at CPOL, and with CPHA=1 data changes on the leading edge and is sampled on the trailing edge. A received byte equals the bits seen on the input at the sample edges, first bit most significant.
- R7: With manual control off, the line chosen by 0x08 [5:4] (0 or 1) is held at its active level for the whole burst and returns to inactive after it. The active level is 0 when 0x08 bit 2 is 1, and 1 otherwise.
- R8: With 0x08 bit 6 set, the chosen line follows 0x08 bit 7 directly and the other line sits at its inactive level.
- R9: Only the first transmit-length bytes of a burst are taken from the transmit FIFO, and later bytes shift 0x00 without popping. A byte slot that finds the transmit FIFO empty also shifts 0x00.
- R10: A received byte that finds the receive FIFO full is dropped, and bit 16 of 0x1C is set. Only a receive FIFO reset or soft reset clears that bit.
- R11: Bit 15 of 0x18 empties the receive FIFO and bit 31 empties the transmit FIFO. Both bits read 0 again one cycle after the write.
- R12: Bit 31 of 0x04 (soft reset) empties both FIFOs, clears the burst and transmit lengths and the start bit, and returns the engine to idle with the clock at rest. The bit clears itself after one cycle.
- R13: While 0x04 bit 7 (pause) is set, the engine does not begin the next byte. It continues once the bit is cleared.
- R14: The serial clock changes only on a divider strobe, one edge per strobe, so there are 16 edges per byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (pops the receive port) |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sck_tick | input | 1 | Half-period strobe from the external divider |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss | output | 2 | Select lines |

## Verification
The bench builds the block with an 8-byte FIFO instead of the default 64. A ten-byte burst then fills the receive FIFO, drops the last two bytes and sets the overflow flag within a few hundred cycles, and a ninth push shows a dropped transmit write. The same burst runs past the two-byte-short transmit FIFO, which exercises the empty-FIFO zero fill. The divider strobe comes every second cycle, so each byte takes about 34 cycles and all four clock modes fit comfortably in the run.

// File: rtl/spix_pkg.sv
package spix_pkg;

  localparam logic [11:0] ADR_GLOBAL = 12'h004;
  localparam logic [11:0] ADR_XFER   = 12'h008;
  localparam logic [11:0] ADR_FCTL   = 12'h018;
  localparam logic [11:0] ADR_FSTAT  = 12'h01C;
  localparam logic [11:0] ADR_BURST  = 12'h030;
  localparam logic [11:0] ADR_XMIT   = 12'h034;
  localparam logic [11:0] ADR_BCTL   = 12'h038;
  localparam logic [11:0] ADR_TXPORT = 12'h200;
  localparam logic [11:0] ADR_RXPORT = 12'h300;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_SHIFT} eng_state_t;

  // Even edge index = leading edge (leaves rest level), odd = trailing.
  function automatic logic f_shift_edge(input logic cpha, input logic odd);
    return cpha ? ~odd : odd;
  endfunction

  function automatic logic f_sample_edge(input logic cpha, input logic odd);
    return cpha ? odd : ~odd;
  endfunction

  // Pin level for a select line that should be asserted (on) or not.
  function automatic logic f_cs_level(input logic active_low, input logic on);
    return active_low ? ~on : on;
  endfunction

endpackage

// File: rtl/spix_fifo.sv
module spix_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] f_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= f_next(wptr);
      if (pop_ok)  rptr <= f_next(rptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);

  a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/spix_engine.sv
module spix_engine
  import spix_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             go,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             pause,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] xmit_len,
  input  logic             tick,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             done,
  input  logic             miso,
  output logic             sck,
  output logic             mosi
);

  eng_state_t       state;
  logic [3:0]       edge_cnt;
  logic [CNT_W-1:0] remaining, sent;
  logic [7:0]       txsh, rxsh, load_byte;
  logic             sck_q, mosi_q;
  logic             use_fifo, take_byte, edge_now, last_edge, byte_done;
  logic             shift_now, sample_now, zero_burst;

  assign use_fifo   = (sent < xmit_len);
  assign take_byte  = (state == ENG_LOAD) && !pause && !srst;
  assign load_byte  = (use_fifo && !tx_empty) ? tx_data : 8'h00;
  assign tx_pop     = take_byte && use_fifo && !tx_empty;
  assign edge_now   = (state == ENG_SHIFT) && tick;
  assign shift_now  = edge_now && f_shift_edge(cpha, edge_cnt[0]);
  assign sample_now = edge_now && f_sample_edge(cpha, edge_cnt[0]);
  assign last_edge  = edge_now && (edge_cnt == 4'd15);
  assign byte_done  = last_edge && !srst;
  assign zero_burst = (state == ENG_IDLE) && go && (burst_len == '0) && !srst;
  assign done       = (byte_done && remaining == CNT_W'(1)) || zero_burst;
  assign busy       = (state != ENG_IDLE);
  assign rx_push    = byte_done;
  assign rx_data    = cpha ? {rxsh[6:0], miso} : rxsh;
  assign sck        = sck_q;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      edge_cnt  <= '0;
      remaining <= '0;
      sent      <= '0;
      txsh      <= '0;
      rxsh      <= '0;
      sck_q     <= 1'b0;
      mosi_q    <= 1'b0;
    end else if (srst) begin
      state     <= ENG_IDLE;
      edge_cnt  <= '0;
      remaining <= '0;
      sent      <= '0;
      sck_q     <= cpol;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          sck_q <= cpol;
          if (go && burst_len != '0) begin
            remaining <= burst_len;
            sent      <= '0;
            state     <= ENG_LOAD;
          end
        end
        ENG_LOAD: begin
          if (!pause) begin
            if (cpha) begin
              txsh <= load_byte;
            end else begin
              txsh   <= {load_byte[6:0], 1'b0};
              mosi_q <= load_byte[7];
            end
            if (use_fifo) sent <= sent + 1'b1;
            edge_cnt <= '0;
            state    <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            sck_q    <= ~sck_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (shift_now) begin
              mosi_q <= txsh[7];
              txsh   <= {txsh[6:0], 1'b0};
            end
            if (sample_now) rxsh <= {rxsh[6:0], miso};
            if (last_edge) begin
              remaining <= remaining - 1'b1;
              state     <= (remaining == CNT_W'(1)) ? ENG_IDLE : ENG_LOAD;
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  a_r14_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_SHIFT && !tick && !srst) |=> ($stable(edge_cnt) && $stable(sck_q)));

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_IDLE && $past(state) == ENG_IDLE && $stable(cpol)) |-> (sck_q == cpol));

  a_r13_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_LOAD && pause && !srst) |=> (state == ENG_LOAD));

endmodule

// File: rtl/spix_master.sv
module spix_master
  import spix_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24,
  parameter int CS_LINES   = 2,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  input  logic        sck_tick,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [CS_LINES-1:0] spi_ss
);

  // global control
  logic g_en, g_master, g_pause, g_srst;
  // transfer control
  logic t_cpha, t_cpol, t_low, t_man, t_lvl, t_start;
  logic [1:0] t_sel;
  // FIFO control and counts
  logic f_rxrst, f_txrst, ovf;
  logic [CNT_W-1:0] burst_len, xmit_len, burst_ctl;

  logic tx_push, tx_pop, tx_full, tx_empty, tx_flush;
  logic rx_push, rx_pop, rx_full, rx_empty, rx_flush;
  logic [7:0] tx_dout, rx_din, rx_dout;
  logic [FCW-1:0] tx_cnt, rx_cnt;
  logic eng_go, eng_busy, eng_done, ovf_event, start_wr;

  assign tx_push   = bus_we && (bus_addr == ADR_TXPORT);
  assign rx_pop    = bus_re && (bus_addr == ADR_RXPORT);
  assign tx_flush  = f_txrst || g_srst;
  assign rx_flush  = f_rxrst || g_srst;
  assign eng_go    = t_start && g_en && g_master;
  assign ovf_event = rx_push && rx_full && !rx_pop;
  assign start_wr  = bus_we && (bus_addr == ADR_XFER) && bus_wdata[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {g_en, g_master, g_pause, g_srst} <= '0;
      {t_cpha, t_cpol, t_low, t_man, t_lvl, t_start} <= '0;
      t_sel     <= '0;
      {f_rxrst, f_txrst, ovf} <= '0;
      burst_len <= '0;
      xmit_len  <= '0;
      burst_ctl <= '0;
    end else begin
      f_rxrst <= 1'b0;
      f_txrst <= 1'b0;
      g_srst  <= 1'b0;
      if (eng_done) t_start <= 1'b0;
      if (rx_flush) ovf <= 1'b0;
      else if (ovf_event) ovf <= 1'b1;
      if (bus_we) begin
        unique case (bus_addr)
          ADR_GLOBAL: begin
            g_en     <= bus_wdata[0];
            g_master <= bus_wdata[1];
            g_pause  <= bus_wdata[7];
            g_srst   <= bus_wdata[31];
          end
          ADR_XFER: begin
            t_cpha  <= bus_wdata[0];
            t_cpol  <= bus_wdata[1];
            t_low   <= bus_wdata[2];
            t_sel   <= bus_wdata[5:4];
            t_man   <= bus_wdata[6];
            t_lvl   <= bus_wdata[7];
            t_start <= bus_wdata[31];
          end
          ADR_FCTL: begin
            f_rxrst <= bus_wdata[15];
            f_txrst <= bus_wdata[31];
          end
          ADR_BURST: burst_len <= bus_wdata[CNT_W-1:0];
          ADR_XMIT:  xmit_len  <= bus_wdata[CNT_W-1:0];
          ADR_BCTL:  burst_ctl <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (g_srst) begin
        t_start   <= 1'b0;
        burst_len <= '0;
        xmit_len  <= '0;
        ovf       <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_GLOBAL: bus_rdata = {g_srst, 23'd0, g_pause, 5'd0, g_master, g_en};
      ADR_XFER:   bus_rdata = {t_start, 23'd0, t_lvl, t_man, t_sel, 1'b0, t_low, t_cpol, t_cpha};
      ADR_FCTL:   bus_rdata = {f_txrst, 15'd0, f_rxrst, 15'd0};
      ADR_FSTAT:  bus_rdata = {15'd0, ovf, 8'(tx_cnt), 8'(rx_cnt)};
      ADR_BURST:  bus_rdata = 32'(burst_len);
      ADR_XMIT:   bus_rdata = 32'(xmit_len);
      ADR_BCTL:   bus_rdata = 32'(burst_ctl);
      ADR_RXPORT: bus_rdata = {24'd0, rx_dout};
      default:    bus_rdata = '0;
    endcase
  end

  spix_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
    .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty)
  );

  spix_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
    .din(rx_din), .pop(rx_pop), .dout(rx_dout), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty)
  );

  spix_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .srst(g_srst), .go(eng_go),
    .cpol(t_cpol), .cpha(t_cpha), .pause(g_pause),
    .burst_len(burst_len), .xmit_len(xmit_len), .tick(sck_tick),
    .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_din), .busy(eng_busy), .done(eng_done),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi)
  );

  for (genvar i = 0; i < CS_LINES; i++) begin : g_cs
    logic chosen;
    assign chosen = (t_sel == 2'(i));
    assign spi_ss[i] = t_man ? (chosen ? t_lvl : f_cs_level(t_low, 1'b0))
                             : f_cs_level(t_low, chosen && eng_busy);
  end

  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !start_wr) |=> !t_start);

  a_r10_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_event && !rx_flush) |=> ovf);

  a_r12_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    g_srst |=> (!eng_busy && !t_start && rx_empty && tx_empty));

  a_r11_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (f_rxrst && !(bus_we && bus_addr == ADR_FCTL)) |=> !f_rxrst);

endmodule

// File: tb/tb_spix_master.sv
`timescale 1ns/1ps
module tb_spix_master;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        sck_tick = 1'b0;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [1:0]  spi_ss;
  logic        miso_inv = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign spi_miso = spi_mosi ^ miso_inv;

  spix_master #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sck_tick(sck_tick), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_ss(spi_ss)
  );

  initial begin
    forever begin
      @(posedge clk);
      sck_tick <= ~sck_tick;
    end
  end

  // line monitor: samples data output at the sample edge of the set mode
  logic       m_cpol = 1'b0, m_cpha = 1'b0;
  int         edges = 0;
  int         nbits = 0;
  logic [7:0] msh = '0;
  logic [7:0] mon_q [$];

  always @(posedge spi_sck or negedge spi_sck) begin
    logic leading;
    edges++;
    leading = (spi_sck != m_cpol);
    if (leading != m_cpha) begin
      msh = {msh[6:0], spi_mosi};
      nbits++;
      if (nbits == 8) begin
        mon_q.push_back(msh);
        nbits = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input bit pop = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_re = pop;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic mon_clear();
    mon_q.delete();
    edges = 0;
    nbits = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(12'h008, v);
      if (!v[31]) break;
    end
  endtask

  task automatic set_xfer(input logic [7:0] cfg);
    wr(12'h008, {24'd0, cfg});
    m_cpha = cfg[0];
    m_cpol = cfg[1];
    repeat (4) @(negedge clk);
    mon_clear();
  endtask

  task automatic go(input logic [7:0] cfg, input int n, input int xm);
    wr(12'h034, xm);
    wr(12'h030, n);
    wr(12'h008, {1'b1, 23'd0, cfg});
  endtask

  task automatic flush_all();
    wr(12'h018, 32'h8000_8000);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h004, v); chk("R1 global", v, 0);
    rd(12'h008, v); chk("R1 xfer", v, 0);
    rd(12'h01C, v); chk("R1 status", v, 0);
    chk("R1 ss", {30'd0, spi_ss}, 0);
    chk("R1 sck/mosi", {30'd0, spi_sck, spi_mosi}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, v); chk("R2 burst width", v, 32'h00FF_FFFF);
    wr(12'h034, 32'h1234_5678); rd(12'h034, v); chk("R2 xmit width", v, 32'h0034_5678);
    wr(12'h038, 32'hFFFF_FFFF); rd(12'h038, v); chk("R2 bctl width", v, 32'h00FF_FFFF);
    wr(12'h008, 32'h0000_00FF); rd(12'h008, v); chk("R2 xfer fields", v, 32'h0000_00F7);
    wr(12'h008, 0);
  endtask

  task automatic t_txfull();
    logic [31:0] v;
    for (int i = 0; i < DEPTH + 1; i++) wr(12'h200, i);
    rd(12'h01C, v); chk("R3 tx full drop", v[15:8], DEPTH);
    flush_all();
  endtask

  task automatic t_mode(input int m);
    logic [31:0] v;
    logic [7:0] pat [3];
    logic [7:0] cfg;
    pat[0] = 8'h1E + 8'(m); pat[1] = 8'h3A; pat[2] = 8'hD4;
    cfg = {6'd0, 2'(m) == 2'd1 ? 2'b01 : 2'(m) == 2'd2 ? 2'b10 : 2'(m) == 2'd3 ? 2'b11 : 2'b00};
    cfg = {6'd0, cfg[0] ? 1'b0 : 1'b0, 1'b0} | {6'd0, 2'(m)};
    cfg = {6'd0, 1'(m >> 1), 1'(m)};
    miso_inv = 1'(m);
    set_xfer(cfg);
    for (int i = 0; i < 3; i++) wr(12'h200, pat[i]);
    go(cfg, 3, 3);
    wait_idle();
    rd(12'h008, v); chk($sformatf("R4 start cleared m%0d", m), v[31], 0);
    rd(12'h01C, v); chk($sformatf("R4 rx count m%0d", m), v[7:0], 3);
    chk($sformatf("R14 edges m%0d", m), edges, 48);
    chk($sformatf("R6 rest level m%0d", m), spi_sck, cfg[1]);
    chk($sformatf("R5 captured m%0d", m), mon_q.size(), 3);
    for (int i = 0; i < 3; i++) begin
      if (mon_q.size() > i) chk($sformatf("R5 msb first m%0d b%0d", m, i), mon_q[i], pat[i]);
      rd(12'h300, v, 1'b1);
      chk($sformatf("R6 rx byte m%0d b%0d", m, i), v[7:0], pat[i] ^ {8{miso_inv}});
    end
    miso_inv = 1'b0;
  endtask

  task automatic t_nostart();
    logic [31:0] v;
    wr(12'h004, 0);
    set_xfer(8'h00);
    wr(12'h200, 8'h5A);
    go(8'h00, 1, 1);
    repeat (100) @(negedge clk);
    chk("R4 no edges when disabled", edges, 0);
    rd(12'h008, v); chk("R4 start pending", v[31], 1);
    wr(12'h004, 3);
    wait_idle();
    rd(12'h01C, v); chk("R4 runs once enabled", v[7:0], 1);
    flush_all();
  endtask

  task automatic t_autocs();
    logic [31:0] v;
    set_xfer(8'h14);
    chk("R7 idle inactive low", spi_ss, 2'b11);
    wr(12'h200, 1); wr(12'h200, 2);
    go(8'h14, 2, 2);
    repeat (12) @(negedge clk);
    chk("R7 asserted during burst", spi_ss, 2'b01);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R7 released after burst", spi_ss, 2'b11);
    set_xfer(8'h00);
    chk("R7 idle inactive high", spi_ss, 2'b00);
    flush_all();
  endtask

  task automatic t_mancs();
    set_xfer(8'h44); chk("R8 manual level0 line0", spi_ss, 2'b10);
    set_xfer(8'hC4); chk("R8 manual level1 line0", spi_ss, 2'b11);
    set_xfer(8'h54); chk("R8 manual level0 line1", spi_ss, 2'b01);
    set_xfer(8'h00);
  endtask

  task automatic t_xmit_limit();
    logic [31:0] v;
    set_xfer(8'h00);
    wr(12'h200, 8'hA7); wr(12'h200, 8'h6B);
    go(8'h00, 3, 1);
    wait_idle();
    chk("R9 slots", mon_q.size(), 3);
    if (mon_q.size() == 3) begin
      chk("R9 first from fifo", mon_q[0], 8'hA7);
      chk("R9 beyond xmit zero", {mon_q[1], mon_q[2]}, 16'h0000);
    end
    rd(12'h01C, v); chk("R9 no pop beyond xmit", v[15:8], 1);
    flush_all();
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    set_xfer(8'h00);
    for (int i = 0; i < DEPTH; i++) wr(12'h200, 8'h40 + i);
    go(8'h00, DEPTH + 2, DEPTH + 2);
    wait_idle();
    chk("R9 slots incl empty", mon_q.size(), DEPTH + 2);
    if (mon_q.size() == DEPTH + 2)
      chk("R9 empty fifo zero", {mon_q[DEPTH], mon_q[DEPTH+1]}, 16'h0000);
    rd(12'h01C, v);
    chk("R10 rx held at depth", v[7:0], DEPTH);
    chk("R10 overflow flag", v[16], 1);
    rd(12'h300, v, 1'b1); chk("R10 oldest kept", v[7:0], 8'h40);
    wr(12'h018, 32'h0000_8000);
    rd(12'h018, v); chk("R11 rx reset self clears", v, 0);
    rd(12'h01C, v); chk("R11 rx emptied and flag cleared", v, 0);
    for (int i = 0; i < 3; i++) wr(12'h200, i);
    rd(12'h01C, v); chk("R3 tx count", v[15:8], 3);
    wr(12'h018, 32'h8000_0000);
    rd(12'h01C, v); chk("R11 tx reset", v[15:8], 0);
  endtask

  task automatic t_pause();
    logic [31:0] v;
    set_xfer(8'h00);
    wr(12'h004, 32'h83);
    wr(12'h200, 8'h11); wr(12'h200, 8'h22);
    go(8'h00, 2, 2);
    repeat (100) @(negedge clk);
    chk("R13 held while paused", edges, 0);
    wr(12'h004, 32'h03);
    wait_idle();
    chk("R13 resumes", edges, 32);
    rd(12'h01C, v); chk("R13 bytes received", v[7:0], 2);
    flush_all();
  endtask

  task automatic t_srst();
    logic [31:0] v;
    int e;
    set_xfer(8'h02);
    for (int i = 0; i < 4; i++) wr(12'h200, 8'h90 + i);
    go(8'h02, 4, 4);
    for (int i = 0; i < 400 && edges < 10; i++) @(negedge clk);
    wr(12'h004, 32'h8000_0003);
    repeat (2) @(negedge clk);
    rd(12'h004, v); chk("R12 self clears", v, 3);
    rd(12'h01C, v); chk("R12 fifos empty", v, 0);
    rd(12'h030, v); chk("R12 burst cleared", v, 0);
    rd(12'h034, v); chk("R12 xmit cleared", v, 0);
    rd(12'h008, v); chk("R12 start cleared", v[31], 0);
    chk("R12 clock at rest", spi_sck, 1'b1);
    e = edges;
    repeat (60) @(negedge clk);
    chk("R12 engine idle", edges, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_txfull();
    t_nostart();
    for (int m = 0; m < 4; m++) t_mode(m);
    t_autocs();
    t_mancs();
    t_xmit_limit();
    t_overflow();
    t_pause();
    t_srst();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule